// File: doc/BRIEF.md
# Shared SRAM Bank Port with Read-Modify-Write and DMA Starvation Guard

This block sits in front of one SRAM bank whose words are eight bytes wide. Three requesters share the bank: a fetch port, a commit port and a DMA port. Each cycle that the bank is free, a fixed-priority arbiter grants at most one of them. Fetch wins over commit, and commit wins over DMA. A read returns the addressed word with only the bytes named by its byte mask kept. A write that covers the whole word is committed in the grant cycle.

The storage can only accept complete words. A write with any byte missing from its mask therefore turns into a three-cycle sequence, and the bank stays held for the whole of it. In the grant cycle the old word is captured. In the second cycle the new bytes are merged under the mask. In the third cycle the merged word is written back. No requester is granted while the sequence runs.

Because DMA has the lowest priority, a counter measures how many cycles in a row a DMA request has been left waiting. When the wait goes past the configured limit, a sticky error flag is raised. Only reset clears it.

Top module: `sram_bank_port`

## Requirements
- R1: After reset, `reqGrant`, `rdValid`, `bankBusy` and `dmaTimeout` are all 0.
- R2: While the bank is free, at most one bit of `reqGrant` is set, and only for a requester whose `reqValid` bit is high. The grant appears combinationally in the same cycle as the request.
- R3: Requester index sets priority. Index 0 is fetch and is served first, index 1 is commit, and the last index is DMA, which is served only when no other requester is active.
- R4: A write whose mask is all ones (8'hFF) updates the word at the grant clock edge. `bankBusy` stays 0 and no read response is produced.
- R5: A write with any mask bit clear holds the bank. `bankBusy` is 1 for the two cycles after the grant and no grant is given during them. Afterwards, bytes with mask bit i set (bits 8i+7:8i) take the new data, and all other bytes keep their old value.
- R6: A granted read sets `rdValid` for one cycle in the cycle after the grant. In that cycle `rdOwner` holds the requester index and `rdData` holds the word with each byte whose mask bit is 0 forced to zero.
- R7: `dmaTimeout` goes to 1 after the DMA request has waited ungranted for TIMEOUT_LIMIT+1 consecutive cycles, and not before.
- R8: The wait count restarts from zero in any cycle where DMA is granted or its request is low. Two waits separated by one idle cycle, each no longer than TIMEOUT_LIMIT, raise no error.
- R9: Once set, `dmaTimeout` stays 1 until reset, even after DMA is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request per requester (0 fetch, 1 commit, last DMA) |
| reqWrite | input | NUM_REQ | 1 = write, 0 = read, per requester |
| reqAddr | input | NUM_REQ*ADDR_W | Word address per requester, packed by index |
| reqData | input | NUM_REQ*DATA_W | Write data per requester, packed by index |
| reqMask | input | NUM_REQ*DATA_W/8 | Byte mask per requester, packed by index |
| reqGrant | output | NUM_REQ | One-hot grant, same cycle as request |
| rdValid | output | 1 | Read response strobe |
| rdOwner | output | clog2(NUM_REQ) | Index of the requester the response belongs to |
| rdData | output | DATA_W | Masked read word |
| bankBusy | output | 1 | Read-modify-write in progress |
| dmaTimeout | output | 1 | Sticky DMA starvation error |

## Verification
Several properties are checked on every cycle. The grant is one-hot or empty. Nothing is granted while the bank is busy, and DMA is never granted over an active higher-priority request. Every busy period lasts exactly two cycles. A read grant is always followed by a response tagged with the right owner. The error flag never falls, and it can only rise after a cycle of DMA waiting. Some behaviours can only be shown by the bench's scenarios. These are the actual merged byte values and the masked read contents, the exact cycle at which the timeout fires, and the fact that a one-cycle drop of the DMA request restarts the count.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_WBACK = 2'd2
  } bankState_e;

  typedef struct packed {
    logic doRead;
    logic doFullWrite;
    logic doRmwRead;
    logic doMerge;
    logic doWriteBack;
  } bankStrobes_t;

endpackage

// File: rtl/sram_prio_arbiter.sv
module sram_prio_arbiter #(
  parameter int NUM_REQ = 3,
  localparam int IDX_W = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_REQ-1:0] reqValid,
  output logic [NUM_REQ-1:0] grant,
  output logic [IDX_W-1:0]   grantIdx
);

  logic [NUM_REQ:0] seenHigher;
  assign seenHigher[0] = 1'b0;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_prio
    assign seenHigher[i+1] = seenHigher[i] | reqValid[i];
    assign grant[i] = enable & reqValid[i] & ~seenHigher[i];
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (grant[i]) grantIdx = IDX_W'(i);
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant) && ((grant & ~reqValid) == '0));

  p_dma_lowest_r3: assert property (@(posedge clk) disable iff (!rstN)
    grant[NUM_REQ-1] |-> (reqValid[NUM_REQ-2:0] == '0));

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sram_bank_pkg::*;
#(
  parameter int NUM_REQ       = 3,
  parameter int MASK_W        = 8,
  parameter int TIMEOUT_LIMIT = 4096,
  localparam int IDX_W = $clog2(NUM_REQ),
  localparam int CNT_W = $clog2(TIMEOUT_LIMIT + 1),
  localparam int DMA_IDX = NUM_REQ - 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ-1:0]        reqWrite,
  input  logic [NUM_REQ*MASK_W-1:0] reqMask,
  output logic [NUM_REQ-1:0]        grant,
  output logic [IDX_W-1:0]          sel,
  output bankStrobes_t              strobes,
  output logic                      bankBusy,
  output logic                      dmaTimeout
);

  bankState_e state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic dmaWaiting;
  logic fullMask;

  sram_prio_arbiter #(.NUM_REQ(NUM_REQ)) i_arb (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (state == ST_IDLE),
    .reqValid (reqValid),
    .grant    (grant),
    .grantIdx (sel)
  );

  assign fullMask = &reqMask[sel*MASK_W +: MASK_W];

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (|grant) begin
          if (!reqWrite[sel]) begin
            strobes.doRead = 1'b1;
          end else if (fullMask) begin
            strobes.doFullWrite = 1'b1;
          end else begin
            strobes.doRmwRead = 1'b1;
            stateNext = ST_MERGE;
          end
        end
      end
      ST_MERGE: begin
        strobes.doMerge = 1'b1;
        stateNext = ST_WBACK;
      end
      ST_WBACK: begin
        strobes.doWriteBack = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign bankBusy = (state != ST_IDLE);

  // DMA starvation watchdog
  assign dmaWaiting = reqValid[DMA_IDX] & ~grant[DMA_IDX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt    <= '0;
      dmaTimeout <= 1'b0;
    end else begin
      if (!dmaWaiting)                          waitCnt <= '0;
      else if (waitCnt != CNT_W'(TIMEOUT_LIMIT)) waitCnt <= waitCnt + 1'b1;
      if (dmaWaiting && waitCnt == CNT_W'(TIMEOUT_LIMIT)) dmaTimeout <= 1'b1;
    end
  end

  p_no_grant_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    bankBusy |-> (grant == '0));

  p_busy_enter_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bankBusy) |=> bankBusy);

  p_busy_leave_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bankBusy && $past(bankBusy)) |=> !bankBusy);

  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaTimeout |=> dmaTimeout);

  p_timeout_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaTimeout) |-> $past(dmaWaiting));

endmodule

// File: rtl/sram_bank_datapath.sv
module sram_bank_datapath
  import sram_bank_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 64,
  localparam int MASK_W = DATA_W / 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobes_t              strobes,
  input  logic [IDX_W-1:0]          sel,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqData,
  input  logic [NUM_REQ*MASK_W-1:0] reqMask,
  output logic                      rdValid,
  output logic [IDX_W-1:0]          rdOwner,
  output logic [DATA_W-1:0]         rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [MASK_W-1:0] selMask;
  logic [DATA_W-1:0] selWord;

  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic [MASK_W-1:0] holdMask;
  logic [DATA_W-1:0] holdWord;

  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] readMasked;

  assign selAddr = reqAddr[sel*ADDR_W +: ADDR_W];
  assign selData = reqData[sel*DATA_W +: DATA_W];
  assign selMask = reqMask[sel*MASK_W +: MASK_W];
  assign selWord = mem[selAddr];

  for (genvar b = 0; b < MASK_W; b++) begin : g_byte
    assign mergedWord[b*8 +: 8] = holdMask[b] ? holdData[b*8 +: 8] : holdWord[b*8 +: 8];
    assign readMasked[b*8 +: 8] = selMask[b] ? selWord[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (strobes.doFullWrite)      mem[selAddr]  <= selData;
    else if (strobes.doWriteBack) mem[holdAddr] <= holdWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      holdMask <= '0;
      holdWord <= '0;
    end else if (strobes.doRmwRead) begin
      holdAddr <= selAddr;
      holdData <= selData;
      holdMask <= selMask;
      holdWord <= selWord;
    end else if (strobes.doMerge) begin
      holdWord <= mergedWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdOwner <= '0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.doRead;
      if (strobes.doRead) begin
        rdOwner <= sel;
        rdData  <= readMasked;
      end
    end
  end

  p_read_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doRead |=> (rdValid && rdOwner == $past(sel)));

  p_merge_after_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doRmwRead |=> strobes.doMerge);

endmodule

// File: rtl/sram_bank_port.sv
module sram_bank_port
  import sram_bank_pkg::*;
#(
  parameter int NUM_REQ       = 3,
  parameter int DATA_W        = 64,
  parameter int DEPTH         = 64,
  parameter int TIMEOUT_LIMIT = 4096,
  localparam int MASK_W = DATA_W / 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ-1:0]        reqWrite,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqData,
  input  logic [NUM_REQ*MASK_W-1:0] reqMask,
  output logic [NUM_REQ-1:0]        reqGrant,
  output logic                      rdValid,
  output logic [IDX_W-1:0]          rdOwner,
  output logic [DATA_W-1:0]         rdData,
  output logic                      bankBusy,
  output logic                      dmaTimeout
);

  bankStrobes_t strobes;
  logic [IDX_W-1:0] sel;

  sram_bank_ctrl #(
    .NUM_REQ(NUM_REQ), .MASK_W(MASK_W), .TIMEOUT_LIMIT(TIMEOUT_LIMIT)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqMask    (reqMask),
    .grant      (reqGrant),
    .sel        (sel),
    .strobes    (strobes),
    .bankBusy   (bankBusy),
    .dmaTimeout (dmaTimeout)
  );

  sram_bank_datapath #(
    .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .sel     (sel),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .reqMask (reqMask),
    .rdValid (rdValid),
    .rdOwner (rdOwner),
    .rdData  (rdData)
  );

endmodule

// File: tb/test_sram_bank_port.sv
module test_sram_bank_port;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 4096;
  localparam int AW = 6;

  typedef struct packed {
    logic [1:0]  idx;
    logic        wr;
    logic [5:0]  addr;
    logic [63:0] data;
    logic [7:0]  mask;
    logic [63:0] expect_;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 6'd3,  64'h1122334455667788, 8'hFF, 64'h0},
    '{2'd1, 1'b0, 6'd3,  64'h0,                8'hFF, 64'h1122334455667788},
    '{2'd2, 1'b1, 6'd3,  64'hAAAAAAAAAAAAAAAA, 8'h0F, 64'h0},
    '{2'd0, 1'b0, 6'd3,  64'h0,                8'hFF, 64'h11223344AAAAAAAA},
    '{2'd1, 1'b0, 6'd3,  64'h0,                8'h3C, 64'h00003344AAAA0000},
    '{2'd1, 1'b1, 6'd10, 64'hDEADBEEFCAFEF00D, 8'hFF, 64'h0},
    '{2'd2, 1'b1, 6'd10, 64'h0102030405060708, 8'h81, 64'h0},
    '{2'd2, 1'b0, 6'd10, 64'h0,                8'hFF, 64'h01ADBEEFCAFEF008},
    '{2'd0, 1'b1, 6'd63, 64'h0F0F0F0F0F0F0F0F, 8'hFF, 64'h0},
    '{2'd2, 1'b1, 6'd63, 64'hFFFFFFFFFFFFFFFF, 8'h00, 64'h0},
    '{2'd0, 1'b0, 6'd63, 64'h0,                8'hFF, 64'h0F0F0F0F0F0F0F0F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0]     reqValid = '0;
  logic [2:0]     reqWrite = '0;
  logic [3*AW-1:0] reqAddr = '0;
  logic [191:0]   reqData = '0;
  logic [23:0]    reqMask = '0;
  logic [2:0]     reqGrant;
  logic           rdValid;
  logic [1:0]     rdOwner;
  logic [63:0]    rdData;
  logic           bankBusy;
  logic           dmaTimeout;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bank_port #(.NUM_REQ(3), .DATA_W(64), .DEPTH(64), .TIMEOUT_LIMIT(LIMIT)) i_sram_bank_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .reqMask(reqMask), .reqGrant(reqGrant), .rdValid(rdValid),
    .rdOwner(rdOwner), .rdData(rdData), .bankBusy(bankBusy), .dmaTimeout(dmaTimeout)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setReq(input int idx, input logic wr, input logic [5:0] addr,
                        input logic [63:0] data, input logic [7:0] mask);
    reqValid[idx] = 1'b1;
    reqWrite[idx] = wr;
    reqAddr[idx*AW +: AW] = addr;
    reqData[idx*64 +: 64] = data;
    reqMask[idx*8 +: 8] = mask;
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    reqValid = '0;
    setReq(int'(v.idx), v.wr, v.addr, v.data, v.mask);
    #1;
    chk(reqGrant == (3'b001 << v.idx), "R2 grant", 64'(reqGrant), 64'(3'b001 << v.idx));
    @(negedge clk);
    reqValid = '0;
    if (!v.wr) begin
      chk(rdValid && rdOwner == v.idx && rdData == v.expect_, "R6 read", rdData, v.expect_);
    end else if (v.mask != 8'hFF) begin
      chk(bankBusy, "R5 busy1", 64'(bankBusy), 64'd1);
      @(negedge clk);
      chk(bankBusy, "R5 busy2", 64'(bankBusy), 64'd1);
      @(negedge clk);
      chk(!bankBusy, "R5 free", 64'(bankBusy), 64'd0);
    end else begin
      chk(!bankBusy && !rdValid, "R4 single cycle", 64'({bankBusy, rdValid}), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqGrant == 0 && !rdValid && !bankBusy && !dmaTimeout, "R1 reset state",
        64'({reqGrant, rdValid, bankBusy, dmaTimeout}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqGrant == 0 && !rdValid && !bankBusy && !dmaTimeout, "R1 after reset",
        64'({reqGrant, rdValid, bankBusy, dmaTimeout}), 64'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R3: all three read at once, each held until served
    @(negedge clk);
    setReq(0, 1'b0, 6'd3, 64'h0, 8'hFF);
    setReq(1, 1'b0, 6'd10, 64'h0, 8'hFF);
    setReq(2, 1'b0, 6'd63, 64'h0, 8'hFF);
    #1 chk(reqGrant == 3'b001, "R3 fetch first", 64'(reqGrant), 64'd1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    chk(rdValid && rdOwner == 2'd0, "R3 owner fetch", 64'(rdOwner), 64'd0);
    #1 chk(reqGrant == 3'b010, "R3 commit second", 64'(reqGrant), 64'd2);
    @(negedge clk);
    reqValid[1] = 1'b0;
    chk(rdValid && rdOwner == 2'd1 && rdData == 64'h01ADBEEFCAFEF008, "R3 owner commit",
        rdData, 64'h01ADBEEFCAFEF008);
    #1 chk(reqGrant == 3'b100, "R3 dma last", 64'(reqGrant), 64'd4);
    @(negedge clk);
    reqValid = '0;
    chk(rdValid && rdOwner == 2'd2, "R3 owner dma", 64'(rdOwner), 64'd2);

    // R5: bank held during read-modify-write blocks fetch
    @(negedge clk);
    setReq(2, 1'b1, 6'd3, 64'h00000000000000EE, 8'h01);
    @(negedge clk);
    reqValid = '0;
    setReq(0, 1'b0, 6'd3, 64'h0, 8'hFF);
    #1 chk(reqGrant == 0, "R5 blocked 1", 64'(reqGrant), 64'd0);
    @(negedge clk);
    #1 chk(reqGrant == 0, "R5 blocked 2", 64'(reqGrant), 64'd0);
    @(negedge clk);
    #1 chk(reqGrant == 3'b001, "R5 released", 64'(reqGrant), 64'd1);
    @(negedge clk);
    reqValid = '0;
    chk(rdValid && rdData == 64'h11223344AAAAAAEE, "R5 merged word", rdData, 64'h11223344AAAAAAEE);

    // R8: two waits of LIMIT cycles split by one idle cycle
    @(negedge clk);
    setReq(0, 1'b0, 6'd3, 64'h0, 8'hFF);
    setReq(2, 1'b0, 6'd3, 64'h0, 8'hFF);
    repeat (LIMIT) @(negedge clk);
    chk(!dmaTimeout, "R7 not early", 64'(dmaTimeout), 64'd0);
    reqValid[2] = 1'b0;
    @(negedge clk);
    reqValid[2] = 1'b1;
    repeat (LIMIT) @(negedge clk);
    chk(!dmaTimeout, "R8 count restarted", 64'(dmaTimeout), 64'd0);
    // R7: one more waiting cycle passes the limit
    @(negedge clk);
    chk(dmaTimeout, "R7 timeout raised", 64'(dmaTimeout), 64'd1);

    // R9: serve DMA, flag stays
    reqValid[0] = 1'b0;
    #1 chk(reqGrant == 3'b100, "R9 dma served", 64'(reqGrant), 64'd4);
    @(negedge clk);
    reqValid = '0;
    repeat (3) @(negedge clk);
    chk(dmaTimeout, "R9 sticky", 64'(dmaTimeout), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!dmaTimeout, "R9 reset clears", 64'(dmaTimeout), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule